// File: doc/BRIEF.md
# Thread-Block Admission Allocator

This block decides whether a new thread block may become resident on one multiprocessor. Each request carries a thread count and a registers-per-thread figure. From these the allocator derives the block's register demand and warp count. It compares them against the free register pool, the free warp budget and the limit on resident blocks. If everything fits, it admits the block in one piece. It reserves a private, contiguous register range, returns that range's base address, and assigns a block slot number. If anything does not fit, it holds the request off.

Requests arrive on a valid/ready interface. `req_ready` is computed from the request payload and the current occupancy, so a low ready acts as the stall. While stalled, the requester must hold `req_valid` high and keep the payload stable. The allocator re-evaluates the request every cycle and accepts it in the first cycle in which it fits. A request is never granted in part.

Retirement is signalled on a plain control pair that carries a slot number. All resources held by that slot return to the pools at the next clock edge. An admission decided in the same cycle as a release still sees the state from before the release.

Top module: `blk_admit_alloc`

## Requirements
- R1: Register demand is threads times registers-per-thread, rounded up to whole granules of 256 registers. The register file holds 64 granules (16,384 registers). A request is accepted only if a run of free granules at least that long exists. Example: 256 threads at 20 registers is 20 granules, so three such blocks fit and a fourth stalls.
- R2: The warp count is the thread count divided by 32, rounded up. A request is accepted only if the warps already resident plus its own warps do not exceed 32.
- R3: At most 8 blocks are resident. With 8 resident, every request stalls.
- R4: The granted range starts at the lowest-numbered granule that begins a long enough free run. `gnt_base` equals that granule index times 256.
- R5: The register ranges of resident blocks never overlap, and a granted range was entirely free before the grant.
- R6: `req_ready` is high in a cycle where `req_valid` is high exactly when R1, R2 and R3 all hold for the current state. A stalled request is granted in the first cycle in which it fits.
- R7: `gnt_valid` is high for one cycle, in the cycle after each accepted handshake and at no other time. `gnt_base` and `gnt_slot` are valid alongside it. The slot is the lowest-numbered free slot.
- R8: A release naming a resident slot frees that slot, its granules and its warps at the next edge. A request presented in the following cycle may use them.
- R9: A release naming a slot that is not resident has no effect.
- R10: After reset, no block is resident and `gnt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request fits and is taken this cycle (low = stall) |
| req_threads | input | 11 | Threads in the block, at least 1 |
| req_rpt | input | 8 | Registers per thread, at least 1 |
| gnt_valid | output | 1 | Grant result valid |
| gnt_base | output | 14 | First register of the granted range |
| gnt_slot | output | 3 | Block slot assigned |
| rel_valid | input | 1 | Retire the block in `rel_slot` |
| rel_slot | input | 3 | Slot to retire |

## Verification
`req_ready` is combinational from the payload and the registered state, so the bench checks it one time step after driving each request. That is well before the edge that consumes it. The grant fields come from registers loaded at that edge, so they are checked at the following falling edge. They are compared against the base and slot the bench model predicted when it saw the handshake. A release is applied to the model at the same edge as in the design, so the decision in the release cycle uses the pre-release state and the decision in the next cycle uses the freed resources.

// File: rtl/ba_pkg.sv
package ba_pkg;
  parameter int unsigned DEF_REG_WORDS  = 16384;
  parameter int unsigned DEF_GRAN_WORDS = 256;
  parameter int unsigned DEF_WARP_LANES = 32;
  parameter int unsigned DEF_MAX_WARPS  = 32;
  parameter int unsigned DEF_MAX_BLOCKS = 8;
  parameter int unsigned DEF_THR_W      = 11;
  parameter int unsigned DEF_RPT_W      = 8;
endpackage

// File: rtl/ba_demand.sv
module ba_demand #(
  parameter int unsigned THR_W      = ba_pkg::DEF_THR_W,
  parameter int unsigned RPT_W      = ba_pkg::DEF_RPT_W,
  parameter int unsigned GRAN_WORDS = ba_pkg::DEF_GRAN_WORDS,
  parameter int unsigned WARP_LANES = ba_pkg::DEF_WARP_LANES,
  localparam int unsigned DEM_W     = THR_W + RPT_W + 1,
  localparam int unsigned GBITS     = $clog2(GRAN_WORDS),
  localparam int unsigned LBITS     = $clog2(WARP_LANES)
) (
  input  logic [THR_W-1:0] threads,
  input  logic [RPT_W-1:0] rpt,
  output logic [DEM_W-1:0] gran_need,
  output logic [THR_W:0]   warps
);
  logic [DEM_W-1:0] regs;
  logic [THR_W:0]   thr_ext;

  always_comb begin
    regs      = DEM_W'(threads) * DEM_W'(rpt);
    gran_need = (regs + DEM_W'(GRAN_WORDS - 1)) >> GBITS;
    thr_ext   = {1'b0, threads} + (THR_W+1)'(WARP_LANES - 1);
    warps     = thr_ext >> LBITS;
  end
endmodule

// File: rtl/ba_first_fit.sv
module ba_first_fit #(
  parameter int unsigned NGRAN  = 64,
  parameter int unsigned NEED_W = 20,
  localparam int unsigned GW    = $clog2(NGRAN)
) (
  input  logic [NGRAN-1:0]  occ,
  input  logic [NEED_W-1:0] need,
  output logic              found,
  output logic [GW-1:0]     start
);
  int run;
  int st;

  always_comb begin
    run   = 0;
    st    = 0;
    found = 1'b0;
    start = '0;
    for (int i = 0; i < NGRAN; i++) begin
      if (occ[i]) begin
        run = 0;
      end else begin
        if (run == 0) st = i;
        run = run + 1;
        if (!found && (32'(run) >= 32'(need))) begin
          found = 1'b1;
          start = GW'(st);
        end
      end
    end
  end
endmodule

// File: rtl/ba_slot_table.sv
module ba_slot_table #(
  parameter int unsigned MAX_BLOCKS = 8,
  parameter int unsigned GW         = 6,
  parameter int unsigned LEN_W      = 7,
  parameter int unsigned WCNT_W     = 6,
  localparam int unsigned SLOT_W    = $clog2(MAX_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [GW-1:0]     alloc_start,
  input  logic [LEN_W-1:0]  alloc_len,
  input  logic [WCNT_W-1:0] alloc_warps,
  input  logic              rel_en,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic [MAX_BLOCKS-1:0] slot_vld,
  output logic              free_found,
  output logic [SLOT_W-1:0] free_slot,
  output logic              rel_hit,
  output logic [GW-1:0]     rel_start,
  output logic [LEN_W-1:0]  rel_len,
  output logic [WCNT_W-1:0] rel_warps
);
  logic [GW-1:0]     st_q [MAX_BLOCKS];
  logic [LEN_W-1:0]  ln_q [MAX_BLOCKS];
  logic [WCNT_W-1:0] wp_q [MAX_BLOCKS];

  always_comb begin
    free_found = 1'b0;
    free_slot  = '0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        free_found = 1'b1;
        free_slot  = SLOT_W'(i);
      end
    end
  end

  assign rel_hit   = rel_en && slot_vld[rel_slot];
  assign rel_start = st_q[rel_slot];
  assign rel_len   = ln_q[rel_slot];
  assign rel_warps = wp_q[rel_slot];

  for (genvar g = 0; g < MAX_BLOCKS; g++) begin : g_slot
    wire take = alloc_en && free_found && (free_slot == SLOT_W'(g));
    wire drop = rel_hit && (rel_slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b0;
        st_q[g]     <= '0;
        ln_q[g]     <= '0;
        wp_q[g]     <= '0;
      end else if (take) begin
        slot_vld[g] <= 1'b1;
        st_q[g]     <= alloc_start;
        ln_q[g]     <= alloc_len;
        wp_q[g]     <= alloc_warps;
      end else if (drop) begin
        slot_vld[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk_admit_alloc.sv
module blk_admit_alloc #(
  parameter int unsigned REG_WORDS  = ba_pkg::DEF_REG_WORDS,
  parameter int unsigned GRAN_WORDS = ba_pkg::DEF_GRAN_WORDS,
  parameter int unsigned WARP_LANES = ba_pkg::DEF_WARP_LANES,
  parameter int unsigned MAX_WARPS  = ba_pkg::DEF_MAX_WARPS,
  parameter int unsigned MAX_BLOCKS = ba_pkg::DEF_MAX_BLOCKS,
  parameter int unsigned THR_W      = ba_pkg::DEF_THR_W,
  parameter int unsigned RPT_W      = ba_pkg::DEF_RPT_W,
  localparam int unsigned NGRAN     = REG_WORDS / GRAN_WORDS,
  localparam int unsigned GW        = $clog2(NGRAN),
  localparam int unsigned LEN_W     = GW + 1,
  localparam int unsigned ADDR_W    = $clog2(REG_WORDS),
  localparam int unsigned GBITS     = $clog2(GRAN_WORDS),
  localparam int unsigned SLOT_W    = $clog2(MAX_BLOCKS),
  localparam int unsigned WCNT_W    = $clog2(MAX_WARPS + 1),
  localparam int unsigned DEM_W     = THR_W + RPT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [THR_W-1:0]  req_threads,
  input  logic [RPT_W-1:0]  req_rpt,
  output logic              gnt_valid,
  output logic [ADDR_W-1:0] gnt_base,
  output logic [SLOT_W-1:0] gnt_slot,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot
);
  logic [NGRAN-1:0]      occ;
  logic [WCNT_W-1:0]     warps_used;
  logic [DEM_W-1:0]      gran_need;
  logic [THR_W:0]        warps;
  logic                  fit_found;
  logic [GW-1:0]         fit_start;
  logic [MAX_BLOCKS-1:0] slot_vld;
  logic                  free_found;
  logic [SLOT_W-1:0]     free_slot;
  logic                  rel_hit;
  logic [GW-1:0]         rel_start;
  logic [LEN_W-1:0]      rel_len;
  logic [WCNT_W-1:0]     rel_warps;
  logic                  warp_ok;
  logic                  accept;
  logic [NGRAN-1:0]      occ_nxt;

  ba_demand #(.THR_W(THR_W), .RPT_W(RPT_W), .GRAN_WORDS(GRAN_WORDS),
              .WARP_LANES(WARP_LANES)) i_demand (
    .threads(req_threads), .rpt(req_rpt), .gran_need(gran_need), .warps(warps));

  ba_first_fit #(.NGRAN(NGRAN), .NEED_W(DEM_W)) i_fit (
    .occ(occ), .need(gran_need), .found(fit_found), .start(fit_start));

  ba_slot_table #(.MAX_BLOCKS(MAX_BLOCKS), .GW(GW), .LEN_W(LEN_W),
                  .WCNT_W(WCNT_W)) i_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(accept), .alloc_start(fit_start), .alloc_len(LEN_W'(gran_need)),
    .alloc_warps(WCNT_W'(warps)),
    .rel_en(rel_valid), .rel_slot(rel_slot),
    .slot_vld(slot_vld), .free_found(free_found), .free_slot(free_slot),
    .rel_hit(rel_hit), .rel_start(rel_start), .rel_len(rel_len),
    .rel_warps(rel_warps));

  function automatic logic [NGRAN-1:0] span(input logic [GW-1:0] s,
                                            input logic [LEN_W-1:0] n);
    logic [NGRAN-1:0] m;
    for (int i = 0; i < NGRAN; i++)
      m[i] = (i >= int'(s)) && (i < int'(s) + int'(n));
    return m;
  endfunction

  assign warp_ok   = (32'(warps_used) + 32'(warps)) <= MAX_WARPS;
  assign req_ready = fit_found && warp_ok && free_found;
  assign accept    = req_valid && req_ready;

  always_comb begin
    occ_nxt = occ;
    if (rel_hit) occ_nxt = occ_nxt & ~span(rel_start, rel_len);
    if (accept)  occ_nxt = occ_nxt | span(fit_start, LEN_W'(gran_need));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ        <= '0;
      warps_used <= '0;
      gnt_valid  <= 1'b0;
      gnt_base   <= '0;
      gnt_slot   <= '0;
    end else begin
      occ        <= occ_nxt;
      warps_used <= warps_used - (rel_hit ? rel_warps : '0)
                               + (accept ? WCNT_W'(warps) : '0);
      gnt_valid  <= accept;
      if (accept) begin
        gnt_base <= ADDR_W'(fit_start) << GBITS;
        gnt_slot <= free_slot;
      end
    end
  end
endmodule

// File: rtl/blk_admit_alloc_chk.sv
module blk_admit_alloc_chk #(
  parameter int unsigned NGRAN      = 64,
  parameter int unsigned MAX_BLOCKS = 8,
  parameter int unsigned MAX_WARPS  = 32,
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned GBITS      = 8,
  parameter int unsigned SLOT_W     = 3,
  parameter int unsigned WCNT_W     = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  gnt_valid,
  input logic [ADDR_W-1:0]     gnt_base,
  input logic                  rel_valid,
  input logic [SLOT_W-1:0]     rel_slot,
  input logic [NGRAN-1:0]      occ,
  input logic [MAX_BLOCKS-1:0] slot_vld,
  input logic [WCNT_W-1:0]     warps_used
);
  logic [NGRAN-1:0] occ_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ;
  end

  wire [ADDR_W-GBITS-1:0] g_idx = gnt_base[ADDR_W-1:GBITS];

  a_r7_grant_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> gnt_valid);
  a_r7_no_stray_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !gnt_valid);
  a_r3_block_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_vld) |-> !req_ready);
  a_r2_warp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(warps_used) <= MAX_WARPS);
  a_r5_range_was_free: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (!occ_q[g_idx] && occ[g_idx]));
  a_r8_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && slot_vld[rel_slot]) |=> !slot_vld[$past(rel_slot)]);
  a_r9_stray_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !slot_vld[rel_slot] && !(req_valid && req_ready)) |=> $stable(occ));
endmodule

bind blk_admit_alloc blk_admit_alloc_chk #(
  .NGRAN(NGRAN), .MAX_BLOCKS(MAX_BLOCKS), .MAX_WARPS(MAX_WARPS),
  .ADDR_W(ADDR_W), .GBITS(GBITS), .SLOT_W(SLOT_W), .WCNT_W(WCNT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .gnt_valid(gnt_valid), .gnt_base(gnt_base), .rel_valid(rel_valid),
  .rel_slot(rel_slot), .occ(occ), .slot_vld(slot_vld), .warps_used(warps_used));

// File: tb/test_blk_admit_alloc.sv
module test_blk_admit_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [10:0] req_threads = '0;
  logic [7:0]  req_rpt = '0;
  logic gnt_valid;
  logic [13:0] gnt_base;
  logic [2:0]  gnt_slot;
  logic rel_valid = 1'b0;
  logic [2:0] rel_slot = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_admit_alloc i_blk_admit_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_rpt(req_rpt), .gnt_valid(gnt_valid),
    .gnt_base(gnt_base), .gnt_slot(gnt_slot), .rel_valid(rel_valid),
    .rel_slot(rel_slot));

  int n_chk = 0;
  int n_fail = 0;

  bit m_occ [64];
  bit m_sv  [8];
  int m_st [8];
  int m_ln [8];
  int m_wp [8];
  int m_wused = 0;
  bit pend = 0;
  int pbase = 0;
  int pslot = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int first_fit(input int need);
    int run = 0;
    int st = 0;
    for (int i = 0; i < 64; i++) begin
      if (m_occ[i]) run = 0;
      else begin
        if (run == 0) st = i;
        run++;
        if (run >= need) return st;
      end
    end
    return -1;
  endfunction

  function automatic int low_free_slot();
    for (int i = 0; i < 8; i++) if (!m_sv[i]) return i;
    return -1;
  endfunction

  // one cycle: check last grant, drive, check ready, advance model
  task automatic step(input bit v, input int thr, input int rpt,
                      input bit rv, input int rs, output bit rdy);
    int need, w, ff, fs;
    bit exp_rdy;
    @(negedge clk);
    chk("R7 gnt_valid", int'(gnt_valid), int'(pend));
    if (pend) begin
      chk("R4 gnt_base", int'(gnt_base), pbase);
      chk("R7 gnt_slot", int'(gnt_slot), pslot);
    end
    req_valid = v; req_threads = 11'(thr); req_rpt = 8'(rpt);
    rel_valid = rv; rel_slot = 3'(rs);
    #1;
    need = (thr * rpt + 255) / 256;
    w    = (thr + 31) / 32;
    ff   = first_fit(need);
    fs   = low_free_slot();
    exp_rdy = (ff >= 0) && (m_wused + w <= 32) && (fs >= 0);
    rdy = req_ready;
    if (v) chk("R6 req_ready", int'(req_ready), int'(exp_rdy));
    pend = v && exp_rdy;
    pbase = ff * 256;
    pslot = fs;
    if (rv && m_sv[rs]) begin
      for (int i = m_st[rs]; i < m_st[rs] + m_ln[rs]; i++) m_occ[i] = 0;
      m_wused -= m_wp[rs];
      m_sv[rs] = 0;
    end
    if (pend) begin
      for (int i = ff; i < ff + need; i++) m_occ[i] = 1;
      m_wused += w;
      m_sv[fs] = 1; m_st[fs] = ff; m_ln[fs] = need; m_wp[fs] = w;
    end
  endtask

  task automatic release_all();
    bit r;
    for (int s = 0; s < 8; s++) if (m_sv[s]) step(0, 1, 1, 1, s, r);
    step(0, 1, 1, 0, 0, r);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit r;
    int thr, rpt;
    bit hold;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R10 gnt_valid after reset", int'(gnt_valid), 0);

    // R1: 256 x 20 = 5120 registers = 20 granules; three fit, fourth stalls
    for (int k = 0; k < 3; k++) begin
      step(1, 256, 20, 0, 0, r);
      chk("R1 block fits", int'(r), 1);
    end
    step(1, 256, 20, 0, 0, r);
    chk("R1 fourth block stalls", int'(r), 0);
    // R8: release slot 1 while held; pre-release state still stalls
    step(1, 256, 20, 1, 1, r);
    chk("R8 same-cycle release not yet visible", int'(r), 0);
    step(1, 256, 20, 0, 0, r);
    chk("R8 freed range reused", int'(r), 1);
    chk("R4 hole at granule 20", pbase, 5120);
    step(0, 1, 1, 0, 0, r);
    release_all();
    // R9: stray release, then the full file must still be free
    step(0, 1, 1, 1, 5, r);
    step(1, 512, 32, 0, 0, r);
    chk("R9 whole file free after stray release", int'(r), 1);
    chk("R4 full file base", pbase, 0);
    step(0, 1, 1, 0, 0, r);
    release_all();

    // R2: 256 threads = 8 warps; four fill 32 warps
    for (int k = 0; k < 4; k++) step(1, 256, 1, 0, 0, r);
    step(1, 1, 1, 0, 0, r);
    chk("R2 warp budget full", int'(r), 0);
    step(0, 1, 1, 1, 0, r);
    step(1, 257, 1, 0, 0, r);
    chk("R2 257 threads round to 9 warps", int'(r), 0);
    step(1, 256, 1, 0, 0, r);
    chk("R2 8 warps fit", int'(r), 1);
    step(0, 1, 1, 0, 0, r);
    release_all();

    // R3: eight small blocks, ninth stalls
    for (int k = 0; k < 8; k++) step(1, 32, 1, 0, 0, r);
    step(1, 32, 1, 0, 0, r);
    chk("R3 ninth block stalls", int'(r), 0);
    step(0, 1, 1, 0, 0, r);
    release_all();

    // random traffic, payload held while stalled
    hold = 0; thr = 1; rpt = 1;
    for (int c = 0; c < 4000; c++) begin
      bit v, rv;
      if (!hold) begin
        thr = 1 + int'($urandom % 512);
        rpt = 1 + int'($urandom % 24);
        v = ($urandom % 3) != 0;
      end else v = 1;
      rv = ($urandom % 4) == 0;
      step(v, thr, rpt, rv, int'($urandom % 8), r);
      hold = v && !r;
    end
    step(0, 1, 1, 0, 0, r);
    step(0, 1, 1, 0, 0, r);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule